// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block produces the serial clock for an I2C master. The clock is built from two phases, low and high, and each phase has its own length. Each length is an 8-bit divider scaled by a shared power-of-two prescaler, plus a fixed overhead of four system clocks. Because the two phases are set separately, the minimum low time and the minimum high time of a bus speed can each be met without stretching the other.

The block also gives the byte engine single-cycle strobes. One fires on the first cycle of each phase and one fires in the middle of each phase, so the engine knows when to launch data and when to sample it. The engine can also ask for the clock to be held low at the end of a low phase. The settings are taken from one packed configuration word. That word is latched only while the generator is disabled, so a clock that is running never changes shape partway through. Working out divider values from a target bus speed is left to software.

Top module: `scl_gen`

## Requirements
- R1: The configuration word holds the low divider in bits 7:0, the high divider in bits 15:8 and the prescaler exponent in bits 18:16. Bits 31:19 have no effect on the waveform.
- R2: The low phase (sclOut = 0) lasts lowDiv * 2^exp + 4 system clocks, for every divider value including 0 and every exponent up to 7.
- R3: The high phase (sclOut = 1 while enabled) lasts highDiv * 2^exp + 4 system clocks.
- R4: The word 0x0001D0D0 gives a low phase of 420 cycles and a high phase of 420 cycles.
- R5: The word 0x0000656A gives a low phase of 110 cycles and a high phase of 105 cycles.
- R6: The configuration word is latched on each clock edge at which enable is low. Changes to the word while the generator is enabled have no effect until it has been disabled and enabled again.
- R7: While enable is low, or during reset, sclOut is 1 and no strobe fires; this holds from the first cycle after an edge at which enable is sampled low. After the first edge at which enable is sampled high, the generator starts a low phase.
- R8: While hold is high, the generator stays in the low phase once that phase reaches its end, and it moves to the high phase on the first edge at which hold is sampled low. Hold has no effect on the length of a high phase.
- R9: lowStartStb or highStartStb is high on the first cycle of its phase. lowMidStb or highMidStb is high on the cycle that lies floor(L/2) cycles after the phase start, where L is that phase's length.
- R10: At most one of the four strobes is high in any cycle. Each one fires once per phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 32 | Packed configuration: low divider, high divider, prescaler exponent |
| enable | input | 1 | Runs the generator when high; releases SCL and latches cfgWord when low |
| hold | input | 1 | Byte-engine request to keep SCL low at the end of the low phase |
| sclOut | output | 1 | SCL drive level (1 = released) |
| lowStartStb | output | 1 | First cycle of a low phase |
| lowMidStb | output | 1 | Middle cycle of a low phase |
| highStartStb | output | 1 | First cycle of a high phase |
| highMidStb | output | 1 | Middle cycle of a high phase |

## Verification
A per-cycle reference model runs alongside phase-length measurements. Several configuration patterns are tried:
- The two worked example words. They separate a correct prescaler shift and overhead term from a plain divide-by-N.
- A word with junk in the upper bits, which shows whether the field boundaries are right.
- Exponents of 3 and 7 with unequal dividers, which catch a low and high swap or a truncated shift.
- All-zero dividers, which give the shortest phase of four cycles.

Further runs check the mid-strobe rounding on odd and even lengths. A word changed while the generator is running, and then applied on re-enable, tells correct latching apart from live use of the word. Hold raised in the low phase and in the high phase shows that stretching applies to the low phase only.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;
  // commands from control to datapath
  typedef struct packed {
    logic capture;  // latch the configuration word
    logic clear;    // reset the phase counter
    logic inc;      // advance the phase counter
  } cmd_t;

  // counter status from datapath to control
  typedef struct packed {
    logic isZero;
    logic isMid;
    logic isLast;
  } status_t;
endpackage

// File: rtl/scl_gen_dp.sv
`timescale 1ns/1ps
module scl_gen_dp
  import scl_gen_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int DIV_W = 8,
  parameter int PRE_W = 3,
  parameter int OVERHEAD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  cmd_t             cmd,
  input  logic             selHigh,
  output status_t          status
);
  localparam int USED_W = 2 * DIV_W + PRE_W;
  localparam int CNT_W  = DIV_W + (1 << PRE_W);

  logic [DIV_W-1:0] lowDiv, highDiv;
  logic [PRE_W-1:0] expSel;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] lowLen, highLen, curLen;

  generate
    if (CFG_W > USED_W) begin : g_spare
      logic unusedCfg;
      assign unusedCfg = ^cfgWord[CFG_W-1:USED_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowDiv  <= '0;
      highDiv <= '0;
      expSel  <= '0;
    end else if (cmd.capture) begin
      lowDiv  <= cfgWord[DIV_W-1:0];
      highDiv <= cfgWord[2*DIV_W-1:DIV_W];
      expSel  <= cfgWord[USED_W-1:2*DIV_W];
    end
  end

  always_comb begin
    lowLen  = ({{(CNT_W-DIV_W){1'b0}}, lowDiv}  << expSel) + CNT_W'(OVERHEAD);
    highLen = ({{(CNT_W-DIV_W){1'b0}}, highDiv} << expSel) + CNT_W'(OVERHEAD);
    curLen  = selHigh ? highLen : lowLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          phaseCnt <= '0;
    else if (cmd.clear) phaseCnt <= '0;
    else if (cmd.inc)   phaseCnt <= phaseCnt + 1'b1;
  end

  assign status.isZero = (phaseCnt == '0);
  assign status.isMid  = (phaseCnt == (curLen >> 1));
  assign status.isLast = (phaseCnt == curLen - 1'b1);
endmodule

// File: rtl/scl_gen_ctrl.sv
`timescale 1ns/1ps
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    hold,
  input  status_t status,
  output cmd_t    cmd,
  output logic    selHigh,
  output logic    sclOut,
  output logic    lowStartStb,
  output logic    lowMidStb,
  output logic    highStartStb,
  output logic    highMidStb
);
  logic active;
  logic phaseHigh;
  logic stretchNow;

  assign stretchNow = !phaseHigh && hold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      phaseHigh <= 1'b0;
    end else if (!enable) begin
      active    <= 1'b0;
      phaseHigh <= 1'b0;
    end else if (!active) begin
      active    <= 1'b1;
      phaseHigh <= 1'b0;
    end else if (status.isLast && !stretchNow) begin
      phaseHigh <= !phaseHigh;
    end
  end

  always_comb begin
    cmd.capture = !enable;
    cmd.clear   = !enable || !active || (status.isLast && !stretchNow);
    cmd.inc     = enable && active && !status.isLast;
  end

  assign selHigh      = phaseHigh;
  assign sclOut       = !active || phaseHigh;
  assign lowStartStb  = active && !phaseHigh && status.isZero;
  assign lowMidStb    = active && !phaseHigh && status.isMid;
  assign highStartStb = active && phaseHigh && status.isZero;
  assign highMidStb   = active && phaseHigh && status.isMid;
endmodule

// File: rtl/scl_gen.sv
`timescale 1ns/1ps
module scl_gen
  import scl_gen_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int DIV_W = 8,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             enable,
  input  logic             hold,
  output logic             sclOut,
  output logic             lowStartStb,
  output logic             lowMidStb,
  output logic             highStartStb,
  output logic             highMidStb
);
  cmd_t    cmd;
  status_t status;
  logic    selHigh;

  scl_gen_dp #(.CFG_W(CFG_W), .DIV_W(DIV_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord),
    .cmd(cmd), .selHigh(selHigh), .status(status)
  );

  scl_gen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .hold(hold),
    .status(status), .cmd(cmd), .selHigh(selHigh), .sclOut(sclOut),
    .lowStartStb(lowStartStb), .lowMidStb(lowMidStb),
    .highStartStb(highStartStb), .highMidStb(highMidStb)
  );
endmodule

// File: rtl/scl_gen_chk.sv
`timescale 1ns/1ps
module scl_gen_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic hold,
  input logic sclOut,
  input logic lowStartStb,
  input logic lowMidStb,
  input logic highStartStb,
  input logic highMidStb
);
  // R7
  released_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !lowStartStb && !lowMidStb && !highStartStb && !highMidStb));

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lowStartStb, lowMidStb, highStartStb, highMidStb}));

  // R9
  fall_marks_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |-> lowStartStb);

  // R9
  rise_marks_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclOut) && $past(enable)) |-> highStartStb);

  // R8
  stretch_keeps_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && hold && !sclOut) |=> !sclOut);
endmodule

bind scl_gen scl_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .hold(hold), .sclOut(sclOut),
  .lowStartStb(lowStartStb), .lowMidStb(lowMidStb),
  .highStartStb(highStartStb), .highMidStb(highMidStb)
);

// File: tb/scl_gen_test.sv
`timescale 1ns/1ps
module scl_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        enable = 1'b0;
  logic        hold = 1'b0;
  logic        sclOut, lowStartStb, lowMidStb, highStartStb, highMidStb;

  int    errors = 0;
  int    checks = 0;
  string curReq = "R7";
  bit    finished = 1'b0;

  always #2.5 clk = ~clk;

  scl_gen uut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .enable(enable), .hold(hold),
    .sclOut(sclOut), .lowStartStb(lowStartStb), .lowMidStb(lowMidStb),
    .highStartStb(highStartStb), .highMidStb(highMidStb)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: elapsed time within the current phase
  int          mOn = 0;
  int          mHigh = 0;
  int          mTime = 0;
  logic [31:0] mWord = '0;

  function automatic int phaseLen(input logic [31:0] w, input int hi);
    int d;
    d = hi ? int'(w[15:8]) : int'(w[7:0]);
    return d * (1 << int'(w[18:16])) + 4;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOn = 0; mHigh = 0; mTime = 0; mWord = '0;
    end else if (!enable) begin
      mOn = 0; mHigh = 0; mTime = 0; mWord = cfgWord;
    end else if (mOn == 0) begin
      mOn = 1; mHigh = 0; mTime = 0;
    end else if (mTime + 1 < phaseLen(mWord, mHigh)) begin
      mTime = mTime + 1;
    end else if (!(mHigh == 0 && hold)) begin
      mTime = 0; mHigh = 1 - mHigh;
    end
  end

  always @(negedge clk) begin
    int len;
    len = phaseLen(mWord, mHigh);
    if (!finished) begin
      check(curReq, "sclOut", int'(sclOut), (mOn == 0 || mHigh == 1) ? 1 : 0);
      check(curReq, "lowStartStb", int'(lowStartStb), (mOn == 1 && mHigh == 0 && mTime == 0) ? 1 : 0);
      check(curReq, "lowMidStb", int'(lowMidStb), (mOn == 1 && mHigh == 0 && mTime == len / 2) ? 1 : 0);
      check(curReq, "highStartStb", int'(highStartStb), (mOn == 1 && mHigh == 1 && mTime == 0) ? 1 : 0);
      check(curReq, "highMidStb", int'(highMidStb), (mOn == 1 && mHigh == 1 && mTime == len / 2) ? 1 : 0);
      check("R10", "strobe count", int'(lowStartStb) + int'(lowMidStb) + int'(highStartStb) + int'(highMidStb) > 1 ? 1 : 0, 0);
    end
  end

  task automatic waitLowStart();
    @(negedge clk);
    while (!lowStartStb) @(negedge clk);
  endtask

  task automatic measure(input string req, input int expLo, input int expHi);
    int t, midLo, midHi, lo;
    waitLowStart();
    t = 0; midLo = -1;
    while (!highStartStb) begin
      if (lowMidStb) midLo = t;
      @(negedge clk); t++;
    end
    lo = t;
    t = 0; midHi = -1;
    while (!lowStartStb) begin
      if (highMidStb) midHi = t;
      @(negedge clk); t++;
    end
    check(req, "low length", lo, expLo);
    check(req, "high length", t, expHi);
    check("R9", "low mid offset", midLo, expLo / 2);
    check("R9", "high mid offset", midHi, expHi / 2);
  endtask

  task automatic runCase(input string req, input logic [31:0] w, input int expLo, input int expHi);
    curReq = req;
    @(negedge clk); enable = 1'b0; cfgWord = w;
    @(negedge clk);
    check("R7", "sclOut while off", int'(sclOut), 1);
    check("R7", "strobes while off", int'({lowStartStb, lowMidStb, highStartStb, highMidStb}), 0);
    enable = 1'b1;
    measure(req, expLo, expHi);
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    check("R7", "reset sclOut", int'(sclOut), 1);
    check("R7", "reset strobes", int'({lowStartStb, lowMidStb, highStartStb, highMidStb}), 0);
    rstN = 1'b1;

    runCase("R5", 32'h0000656A, 110, 105);
    runCase("R4", 32'h0001D0D0, 420, 420);
    runCase("R1", 32'hFFF80302, 6, 7);
    runCase("R2", 32'h00030201, 12, 20);
    runCase("R3", 32'h00070301, 132, 388);
    runCase("R2", 32'h00000000, 4, 4);

    // R6: a word written while running is not used until re-enable
    runCase("R6", 32'h00000304, 8, 7);
    cfgWord = 32'h0000FFFF;
    measure("R6", 8, 7);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    measure("R6", 259, 259);

    // R8: stretch the low phase, then try to stretch a high phase
    runCase("R8", 32'h00000505, 9, 9);
    waitLowStart();
    hold = 1'b1;
    repeat (30) @(negedge clk);
    hold = 1'b0;
    t = 30;
    while (!highStartStb) begin @(negedge clk); t++; end
    check("R8", "stretched low length", t, 31);
    hold = 1'b1;
    t = 0;
    while (!lowStartStb) begin @(negedge clk); t++; end
    check("R8", "high length under hold", t, 9);
    hold = 1'b0;
    curReq = "R7";
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R7", "sclOut after disable", int'(sclOut), 1);
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule